// File: doc/BRIEF.md
# Flash Command Decoder and Status Register

This block sits between the host bus and the write engine of a NOR flash controller. Every host write cycle gives it an address and a data word. The low byte of the data is read as a command code. Some commands act in a single cycle: they change the read mode or clear the error bits. Others need a setup cycle followed by a second cycle. That second cycle carries either a confirm code or the address and data of the operation.

When a two-cycle sequence completes, the block checks three things before it starts anything:
- whether the confirm code matches the setup;
- whether the programming supply is reported valid;
- whether the target block is locked.

If all three pass, it starts the operation on the write engine with a one-cycle start pulse that carries the operation kind, the address and the data. It then waits for the engine's done pulse and its pass/fail result.

The block holds the 8-bit status byte. In that byte, the ready bit tracks whether an operation is running. The error bits collect faults over many operations and clear only on an explicit clear command. The block also keeps one lock bit per erase block. The lock-set and lock-clear operations update these bits, but only when the engine reports that the operation succeeded.

Top module: `fcmd_decoder`

## Requirements
- R1: After reset, the read mode is array (rd_mode = 0), the status byte is 80h, the start pulse is low, and no block is locked.
- R2: While the decoder is idle, FFh selects array reads (rd_mode 0), 90h selects identifier reads (rd_mode 1) and 70h selects status reads (rd_mode 2). Any other unlisted code leaves the read mode unchanged.
- R3: 20h followed by D0h starts an erase: op_kind 1, with the address and data of the confirm cycle. The start pulse appears at the edge that captures the confirm cycle. Status bit 7 drops at that same edge.
- R4: Either 40h or 10h, followed by any write, starts a program: op_kind 2, with that write's address and data.
- R5: 60h followed by 01h starts a lock set: op_kind 3. 60h followed by D0h starts a lock clear: op_kind 4. When the engine reports success, a lock set marks the block addressed by the top BLK_W address bits as locked, and a lock clear unlocks every block.
- R6: C0h followed by any write starts a protection-register program: op_kind 5, with that write's address and data.
- R7: A confirm code that does not match its setup sets status bits 5 and 4, starts nothing, and leaves the decoder idle in status read mode.
- R8: When vpen_ok is low at the second cycle, nothing starts and status bit 3 is set.
- R9: An erase or program aimed at a locked block starts nothing. It sets status bit 1, plus bit 5 for an erase or bit 4 for a program.
- R10: A done pulse sets status bit 7 again. If the fail flag is high with it, the pulse also sets bit 5 for an erase or a lock clear, or bit 4 for a program, a lock set or a protection program.
- R11: Status bits 5, 4, 3 and 1 stay set across later operations and clear only on 50h.
- R12: Host writes made while an operation is running have no effect.
- R13: Every two-cycle sequence leaves the decoder in status read mode, and it stays there until a new mode command is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write cycle strobe |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | DATA_W | Host write data; the low byte is the command code |
| vpen_ok | input | 1 | Programming supply is above the lockout level |
| wsm_done | input | 1 | One-cycle pulse from the write engine when it finishes |
| wsm_fail | input | 1 | Result qualifier sampled with wsm_done |
| rd_mode | output | 2 | Read mode: 0 array, 1 identifier, 2 status |
| status | output | 8 | Status byte |
| op_start | output | 1 | One-cycle start pulse to the write engine |
| op_kind | output | 3 | Operation kind, valid with op_start |
| op_addr | output | ADDR_W | Operation address, valid with op_start |
| op_data | output | DATA_W | Operation data, valid with op_start |

## Verification
The lock bits cannot be observed at the ports directly, so the hardest part to reach is the refusal of an operation on a locked block. The stimulus first runs a lock-set sequence and answers it with a passing done pulse. It then aims a program and an erase at that block and checks that neither produces a start pulse and that both raise the locked and error bits. Further runs cover a lock set that fails, followed by a program to the same block that must go through, and a global clear followed by a program that is accepted again.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_STATUS = 2'd2
  } rdmode_t;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_ERASE = 3'd1,
    OP_PROG  = 3'd2,
    OP_LSET  = 3'd3,
    OP_LCLR  = 3'd4,
    OP_PROT  = 3'd5
  } opkind_t;

  localparam logic [7:0] C_ERASE  = 8'h20;
  localparam logic [7:0] C_CONF   = 8'hD0;
  localparam logic [7:0] C_PROG_A = 8'h40;
  localparam logic [7:0] C_PROG_B = 8'h10;
  localparam logic [7:0] C_LOCK   = 8'h60;
  localparam logic [7:0] C_LSET   = 8'h01;
  localparam logic [7:0] C_PROT   = 8'hC0;
  localparam logic [7:0] C_IDENT  = 8'h90;
  localparam logic [7:0] C_ARRAY  = 8'hFF;
  localparam logic [7:0] C_RSTAT  = 8'h70;
  localparam logic [7:0] C_CLRST  = 8'h50;

  // Sticky error flag vector order: {erase, program, supply, locked}
  localparam int EF_ERASE = 3;
  localparam int EF_PROG  = 2;
  localparam int EF_VPEN  = 1;
  localparam int EF_LOCK  = 0;

endpackage

// File: rtl/fcmd_lockbits.sv
module fcmd_lockbits #(
  parameter int BLK_W = 3,
  localparam int NBLK = 1 << BLK_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [BLK_W-1:0] set_blk,
  input  logic             clr_all,
  output logic [NBLK-1:0]  locked_o
);

  logic [NBLK-1:0] lk_q;

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    always_ff @(posedge clk) begin
      if (rst || clr_all) begin
        lk_q[b] <= 1'b0;
      end else if (set_en && (set_blk == BLK_W'(b))) begin
        lk_q[b] <= 1'b1;
      end
    end
  end

  assign locked_o = lk_q;

  // R5: a global clear leaves no block locked
  a_r5_clear_all: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (locked_o == '0));

  // R5: a set marks the addressed block
  a_r5_set_marks: assert property (@(posedge clk) disable iff (rst)
    (set_en && !clr_all) |=> locked_o[$past(set_blk)]);

endmodule

// File: rtl/fcmd_status.sv
module fcmd_status
  import fcmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ready_clr,
  input  logic       ready_set,
  input  logic [3:0] err_set,
  input  logic       err_clr,
  output logic [7:0] sr_o
);

  logic       rdy_q;
  logic [3:0] err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q <= 1'b1;
      err_q <= '0;
    end else begin
      if (ready_clr) begin
        rdy_q <= 1'b0;
      end else if (ready_set) begin
        rdy_q <= 1'b1;
      end
      err_q <= (err_clr ? 4'b0000 : err_q) | err_set;
    end
  end

  assign sr_o = {rdy_q, 1'b0, err_q[EF_ERASE], err_q[EF_PROG],
                 err_q[EF_VPEN], 1'b0, err_q[EF_LOCK], 1'b0};

  // R11: sticky bits survive everything except the clear command
  a_r11_sticky_prog: assert property (@(posedge clk) disable iff (rst)
    (!err_clr && sr_o[4]) |=> sr_o[4]);
  a_r11_sticky_vpen: assert property (@(posedge clk) disable iff (rst)
    (!err_clr && sr_o[3]) |=> sr_o[3]);
  a_r11_sticky_lock: assert property (@(posedge clk) disable iff (rst)
    (!err_clr && sr_o[1]) |=> sr_o[1]);

  // R10: completion restores ready
  a_r10_ready_back: assert property (@(posedge clk) disable iff (rst)
    ready_set |=> sr_o[7]);

endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq
  import fcmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int BLK_W  = 3,
  localparam int NBLK    = 1 << BLK_W,
  localparam int BLK_LSB = ADDR_W - BLK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              vpen_ok,
  input  logic              wsm_done,
  input  logic              wsm_fail,
  input  logic [NBLK-1:0]   locked,
  output logic [1:0]        rd_mode_o,
  output logic              op_start_o,
  output logic [2:0]        op_kind_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              ready_clr,
  output logic              ready_set,
  output logic [3:0]        err_set,
  output logic              err_clr,
  output logic              lk_set,
  output logic              lk_clr,
  output logic [BLK_W-1:0]  lk_blk
);

  typedef enum logic [2:0] {
    S_IDLE, S_ERASE, S_PROG, S_LOCK, S_PROT, S_BUSY
  } st_t;

  st_t               st_q, st_n;
  rdmode_t           mode_q, mode_n;
  opkind_t           kind_n, run_q;
  logic              start_q;
  opkind_t           kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              launch;
  logic [7:0]        cmd;
  logic [BLK_W-1:0]  wblk;

  assign cmd  = wr_data[7:0];
  assign wblk = wr_addr[ADDR_W-1:BLK_LSB];

  always_comb begin
    st_n      = st_q;
    mode_n    = mode_q;
    kind_n    = OP_NONE;
    launch    = 1'b0;
    err_set   = '0;
    err_clr   = 1'b0;
    ready_set = 1'b0;
    lk_set    = 1'b0;
    lk_clr    = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (wr_en) begin
          case (cmd)
            C_ARRAY: mode_n = RM_ARRAY;
            C_IDENT: mode_n = RM_IDENT;
            C_RSTAT: mode_n = RM_STATUS;
            C_CLRST: err_clr = 1'b1;
            C_ERASE: begin st_n = S_ERASE; mode_n = RM_STATUS; end
            C_PROG_A, C_PROG_B: begin st_n = S_PROG; mode_n = RM_STATUS; end
            C_LOCK:  begin st_n = S_LOCK; mode_n = RM_STATUS; end
            C_PROT:  begin st_n = S_PROT; mode_n = RM_STATUS; end
            default: ;
          endcase
        end
      end
      S_ERASE, S_PROG, S_LOCK, S_PROT: begin
        if (wr_en) begin
          st_n   = S_IDLE;
          mode_n = RM_STATUS;
          case (st_q)
            S_ERASE: kind_n = (cmd == C_CONF) ? OP_ERASE : OP_NONE;
            S_PROG:  kind_n = OP_PROG;
            S_LOCK:  kind_n = (cmd == C_LSET) ? OP_LSET :
                              ((cmd == C_CONF) ? OP_LCLR : OP_NONE);
            default: kind_n = OP_PROT;
          endcase
          if (kind_n == OP_NONE) begin
            err_set[EF_ERASE] = 1'b1;
            err_set[EF_PROG]  = 1'b1;
          end else if (!vpen_ok) begin
            err_set[EF_VPEN] = 1'b1;
          end else if (kind_n == OP_ERASE && locked[wblk]) begin
            err_set[EF_LOCK]  = 1'b1;
            err_set[EF_ERASE] = 1'b1;
          end else if (kind_n == OP_PROG && locked[wblk]) begin
            err_set[EF_LOCK] = 1'b1;
            err_set[EF_PROG] = 1'b1;
          end else begin
            launch = 1'b1;
            st_n   = S_BUSY;
          end
        end
      end
      S_BUSY: begin
        if (wsm_done) begin
          st_n      = S_IDLE;
          ready_set = 1'b1;
          if (wsm_fail) begin
            if (run_q == OP_ERASE || run_q == OP_LCLR) begin
              err_set[EF_ERASE] = 1'b1;
            end else begin
              err_set[EF_PROG] = 1'b1;
            end
          end else if (run_q == OP_LSET) begin
            lk_set = 1'b1;
          end else if (run_q == OP_LCLR) begin
            lk_clr = 1'b1;
          end
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      mode_q  <= RM_ARRAY;
      start_q <= 1'b0;
      kind_q  <= OP_NONE;
      run_q   <= OP_NONE;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      st_q    <= st_n;
      mode_q  <= mode_n;
      start_q <= launch;
      if (launch) begin
        kind_q <= kind_n;
        run_q  <= kind_n;
        addr_q <= wr_addr;
        data_q <= wr_data;
      end
    end
  end

  assign ready_clr  = launch;
  assign rd_mode_o  = mode_q;
  assign op_start_o = start_q;
  assign op_kind_o  = kind_q;
  assign op_addr_o  = addr_q;
  assign op_data_o  = data_q;
  assign lk_blk     = addr_q[ADDR_W-1:BLK_LSB];

  // R12: one start per operation, never back to back
  a_r12_start_pulse: assert property (@(posedge clk) disable iff (rst)
    op_start_o |=> !op_start_o);

  // R8: nothing starts unless the supply was valid at the second cycle
  a_r8_vpen_gate: assert property (@(posedge clk) disable iff (rst)
    op_start_o |-> $past(vpen_ok));

  // R13: a started operation leaves status reads selected
  a_r13_status_mode: assert property (@(posedge clk) disable iff (rst)
    op_start_o |-> (rd_mode_o == RM_STATUS));

  // R3: start kind is always a real operation
  a_r3_kind_valid: assert property (@(posedge clk) disable iff (rst)
    op_start_o |-> (op_kind_o != OP_NONE));

endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
  import fcmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int BLK_W  = 3,
  localparam int NBLK = 1 << BLK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              vpen_ok,
  input  logic              wsm_done,
  input  logic              wsm_fail,
  output logic [1:0]        rd_mode,
  output logic [7:0]        status,
  output logic              op_start,
  output logic [2:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);

  logic [NBLK-1:0]  locked;
  logic             ready_clr, ready_set, err_clr, lk_set, lk_clr;
  logic [3:0]       err_set;
  logic [BLK_W-1:0] lk_blk;

  fcmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vpen_ok(vpen_ok), .wsm_done(wsm_done), .wsm_fail(wsm_fail), .locked(locked),
    .rd_mode_o(rd_mode), .op_start_o(op_start), .op_kind_o(op_kind),
    .op_addr_o(op_addr), .op_data_o(op_data), .ready_clr(ready_clr),
    .ready_set(ready_set), .err_set(err_set), .err_clr(err_clr),
    .lk_set(lk_set), .lk_clr(lk_clr), .lk_blk(lk_blk)
  );

  fcmd_status u_status (
    .clk(clk), .rst(rst), .ready_clr(ready_clr), .ready_set(ready_set),
    .err_set(err_set), .err_clr(err_clr), .sr_o(status)
  );

  fcmd_lockbits #(.BLK_W(BLK_W)) u_lock (
    .clk(clk), .rst(rst), .set_en(lk_set), .set_blk(lk_blk),
    .clr_all(lk_clr), .locked_o(locked)
  );

  // R3: a start always coincides with ready low
  a_r3_busy_on_start: assert property (@(posedge clk) disable iff (rst)
    op_start |-> !status[7]);

endmodule

// File: tb/test_fcmd_decoder.sv
module test_fcmd_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        vpen_ok = 1'b1;
  logic        wsm_done = 1'b0;
  logic        wsm_fail = 1'b0;
  logic [1:0]  rd_mode;
  logic [7:0]  status;
  logic        op_start;
  logic [2:0]  op_kind;
  logic [11:0] op_addr;
  logic [15:0] op_data;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;
  logic [30:0] exp_q[$];

  always #10 clk = ~clk;

  fcmd_decoder i_fcmd_decoder (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vpen_ok(vpen_ok), .wsm_done(wsm_done), .wsm_fail(wsm_fail),
    .rd_mode(rd_mode), .status(status), .op_start(op_start), .op_kind(op_kind),
    .op_addr(op_addr), .op_data(op_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_op(logic [2:0] k, logic [11:0] a, logic [15:0] d);
    exp_q.push_back({k, a, d});
  endtask

  task automatic finish_op(bit fail);
    @(negedge clk);
    wsm_done = 1'b1; wsm_fail = fail;
    @(negedge clk);
    wsm_done = 1'b0; wsm_fail = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // Monitor: pops the scoreboard on every start pulse
  always @(negedge clk) begin
    if (!rst && op_start) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R12/R7/R8/R9 unexpected start: actual=%h expected=none",
                 {op_kind, op_addr, op_data});
      end else begin
        chk("R3/R4/R5/R6 start record", {1'b0, op_kind, op_addr, op_data}, {1'b0, exp_q.pop_front()});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 mode", rd_mode, 0);
    chk("R1 status", status, 8'h80);
    chk("R1 start", op_start, 0);

    // R2
    wr(12'h000, 16'h0090); chk("R2 ident", rd_mode, 1);
    wr(12'h000, 16'h0070); chk("R2 status", rd_mode, 2);
    wr(12'h000, 16'h00FF); chk("R2 array", rd_mode, 0);
    wr(12'h000, 16'h00AB); chk("R2 unknown ignored", rd_mode, 0);

    // R3 erase, R12 busy writes, R10 done, R13 mode held
    wr(12'h200, 16'h0020);
    expect_op(3'd1, 12'h234, 16'h00D0);
    wr(12'h234, 16'h00D0);
    chk("R3 ready low", status, 8'h00);
    chk("R3 mode", rd_mode, 2);
    wr(12'h000, 16'h00FF); chk("R12 mode unchanged", rd_mode, 2);
    wr(12'h200, 16'h0020); wr(12'h200, 16'h00D0);
    chk("R12 still busy", status, 8'h00);
    finish_op(1'b0);
    chk("R10 ready", status, 8'h80);
    chk("R13 mode kept", rd_mode, 2);

    // R4 both setup codes
    wr(12'h015, 16'h0040);
    expect_op(3'd2, 12'h015, 16'hBEEF);
    wr(12'h015, 16'hBEEF);
    finish_op(1'b0);
    wr(12'h016, 16'h0010);
    expect_op(3'd2, 12'h016, 16'h1234);
    wr(12'h016, 16'h1234);
    finish_op(1'b1);
    chk("R10 program fail bit4", status, 8'h90);
    wr(12'h000, 16'h0050);
    chk("R11 clear", status, 8'h80);

    // R5 lock set, R9 refusal
    wr(12'h400, 16'h0060);
    expect_op(3'd3, 12'h400, 16'h0001);
    wr(12'h400, 16'h0001);
    finish_op(1'b0);
    wr(12'h410, 16'h0040); wr(12'h410, 16'h5A5A);
    chk("R9 program locked", status, 8'h92);
    wr(12'h400, 16'h0020); wr(12'h400, 16'h00D0);
    chk("R9 erase locked", status, 8'hB2);

    // R11 persistence over a good operation
    wr(12'h010, 16'h0040);
    expect_op(3'd2, 12'h010, 16'h0F0F);
    wr(12'h010, 16'h0F0F);
    chk("R11 busy keeps errors", status, 8'h32);
    finish_op(1'b0);
    chk("R11 errors persist", status, 8'hB2);
    wr(12'h000, 16'h0050);
    chk("R11 clear all", status, 8'h80);

    // R5 clear all locks
    wr(12'h000, 16'h0060);
    expect_op(3'd4, 12'h000, 16'h00D0);
    wr(12'h000, 16'h00D0);
    finish_op(1'b0);
    wr(12'h410, 16'h0040);
    expect_op(3'd2, 12'h410, 16'h5A5A);
    wr(12'h410, 16'h5A5A);
    finish_op(1'b0);
    chk("R5 unlocked program ok", status, 8'h80);

    // R7 mismatched confirms
    wr(12'h000, 16'h0090);
    wr(12'h000, 16'h0020); wr(12'h000, 16'h0033);
    chk("R7 erase mismatch", status, 8'hB0);
    chk("R7 mode", rd_mode, 2);
    wr(12'h000, 16'h0050);
    wr(12'h000, 16'h0060); wr(12'h000, 16'h0077);
    chk("R7 lock mismatch", status, 8'hB0);
    wr(12'h000, 16'h0050);

    // R8 supply invalid
    vpen_ok = 1'b0;
    wr(12'h020, 16'h0040); wr(12'h020, 16'h1111);
    chk("R8 vpen refusal", status, 8'h88);
    vpen_ok = 1'b1;
    wr(12'h000, 16'h0050);

    // R6 protection program with failure
    wr(12'h003, 16'h00C0);
    expect_op(3'd5, 12'h003, 16'h1234);
    wr(12'h003, 16'h1234);
    finish_op(1'b1);
    chk("R6 prot fail bit4", status, 8'h90);
    wr(12'h000, 16'h0050);

    // R10 erase failure sets bit5
    wr(12'h100, 16'h0020);
    expect_op(3'd1, 12'h100, 16'h00D0);
    wr(12'h100, 16'h00D0);
    finish_op(1'b1);
    chk("R10 erase fail bit5", status, 8'hA0);
    wr(12'h000, 16'h0050);

    // R5 failed lock set leaves block unlocked
    wr(12'h600, 16'h0060);
    expect_op(3'd3, 12'h600, 16'h0001);
    wr(12'h600, 16'h0001);
    finish_op(1'b1);
    chk("R5 lock set fail", status, 8'h90);
    wr(12'h000, 16'h0050);
    wr(12'h600, 16'h0040);
    expect_op(3'd2, 12'h600, 16'h5555);
    wr(12'h600, 16'h5555);
    finish_op(1'b0);
    chk("R5 block not locked", status, 8'h80);

    repeat (2) @(negedge clk);
    chk("R3/R4/R5/R6 all starts seen", exp_q.size(), 0);
    finished = 1'b1;
    summary();
  end

endmodule